// File: doc/BRIEF.md
# Multi-core shared interrupt router

This block collects a parameterised number of external interrupt lines (a nonzero multiple of eight) and steers each one to a single interrupt pin of a single core. Every source keeps four pieces of state: a pending bit, an enable bit, a pin-map word and a core-map entry. Each output line, one per (core, pin) pair, is the OR of all sources that are pending, enabled and mapped to exactly that pair. The outputs are computed combinationally from the stored state. A change written through the bus therefore appears right after the clock edge that accepts the write.

Software reaches the state through a simple register port. A request is a one-cycle `bus_valid` pulse, with `bus_write` choosing the direction. The port accepts one access per cycle and has no back-pressure, because nothing downstream can stall it. Read data returns exactly one cycle later, qualified by `bus_rvalid`. The address is `{region[2:0], index}`, where index has clog2(NUM_SRC) bits. The region codes are:

- 0: pending words (read)
- 1: enable words (read)
- 2: set-enable (write-one)
- 3: clear-enable (write-one)
- 4: software trigger (write)
- 5: pin map (per source)
- 6: core map (per source)

For regions 0 to 3 the index is a 32-bit word number. For regions 5 and 6 it is a source number.

Top module: `irq_router`

## Requirements
- R1: After reset every output is low, every pending and enable word reads 0, every pin-map word reads 0x8000_0000 (map flag in bit 31, pin 0), and every core-map word reads 0 (unmapped).
- R2: Pending (region 0) and enable (region 1) read back bit-packed: bit j of word w is source 32w+j. Bits and words for sources at or above NUM_SRC read 0.
- R3: A write to region 2 sets the enable bit of every source whose data bit is 1. A write to region 3 clears the enable bit of every source whose data bit is 1. Zero bits leave a source unchanged.
- R4: Output `core_irq[c*NUM_PINS+p]` is the OR of pending & enabled over all sources mapped to core c and pin p. It reflects a write in the cycle after the accepting edge.
- R5: A pin-map write stores bit 31 (the map flag) and bits 5:0 (the pin number). The write is ignored when the pin number exceeds NUM_PINS-1. A read returns {flag, 25 zero bits, pin}.
- R6: A core-map write with a nonzero data mask stores the index of its lowest set bit, and a read returns 1 shifted left by that index. A zero write unmaps the source, which then reads 0 and drives no output. A mask whose lowest set bit is at or above NUM_CORES is rejected and leaves the entry unchanged.
- R7: A software-trigger write (region 4) names a source in bits 30:0. Bit 31 = 1 sets that source's pending bit and bit 31 = 0 clears it. A source number at or above NUM_SRC is ignored.
- R8: A pending bit follows a level change on its `irq_in` line one edge later, even while the source is disabled. A disabled source adds nothing to any output, and enabling it later lets its pending level through.
- R9: Every read yields `bus_rvalid` and data one cycle after the request. Word indices past the source count read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | External interrupt levels |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3+clog2(NUM_SRC) | {region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| core_irq | output | NUM_CORES*NUM_PINS | Per core and pin interrupt outputs |

## Verification
The properties assume that `bus_addr` region 7 is never written, that a request lasts one cycle, and that no external line changes in the same cycle as a software trigger aimed at the same source. If both happened at once, the trigger would win and the level change would be lost. The bench drives bus requests between edges for exactly one cycle and holds `irq_in` low except in a dedicated phase that uses no triggers. It sweeps every source, core and pin of a 16-source, 3-core, 4-pin build against an arithmetic model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [2:0] {
    RG_PEND    = 3'd0,
    RG_ENAB    = 3'd1,
    RG_SETEN   = 3'd2,
    RG_CLREN   = 3'd3,
    RG_TRIG    = 3'd4,
    RG_PINMAP  = 3'd5,
    RG_COREMAP = 3'd6,
    RG_NONE    = 3'd7
  } region_e;

  localparam int PIN_FIELD_W = 6;
  localparam int FLAG_BIT    = 31;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NUM_SRC-1:0]                      irq_in,
  input  logic                                    wr_en,
  input  region_e                                 wr_region,
  input  logic [IDX_W-1:0]                        wr_index,
  input  logic [31:0]                             wr_data,
  output logic [NUM_SRC-1:0]                      pend_q,
  output logic [NUM_SRC-1:0]                      enab_q,
  output logic [NUM_SRC-1:0][PIN_FIELD_W-1:0]     pin_q,
  output logic [NUM_SRC-1:0]                      pinflag_q,
  output logic [NUM_SRC-1:0]                      core_vld_q,
  output logic [NUM_SRC-1:0][CORE_W-1:0]          core_idx_q
);
  logic [NUM_SRC-1:0] irq_q;
  logic [NUM_SRC-1:0] set_vec, clr_vec;
  logic               set_wr, clr_wr, trig_ok, pinmap_wr, pin_ok, coremap_wr;
  logic [IDX_W-1:0]   trig_src;
  int                 low_bit;

  assign set_wr     = wr_en && (wr_region == RG_SETEN);
  assign clr_wr     = wr_en && (wr_region == RG_CLREN);
  assign pinmap_wr  = wr_en && (wr_region == RG_PINMAP);
  assign coremap_wr = wr_en && (wr_region == RG_COREMAP);
  assign pin_ok     = 32'(wr_data[PIN_FIELD_W-1:0]) < 32'(NUM_PINS);
  assign trig_ok    = wr_en && (wr_region == RG_TRIG) &&
                      ({1'b0, wr_data[30:0]} < 32'(NUM_SRC));
  assign trig_src   = wr_data[IDX_W-1:0];

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      set_vec[s] = set_wr && (wr_index == IDX_W'(s / 32)) && wr_data[s % 32];
      clr_vec[s] = clr_wr && (wr_index == IDX_W'(s / 32)) && wr_data[s % 32];
    end
  end

  always_comb begin
    low_bit = 32;
    for (int b = 31; b >= 0; b--) begin
      if (wr_data[b]) low_bit = b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q      <= '0;
      pend_q     <= '0;
      enab_q     <= '0;
      pin_q      <= '0;
      pinflag_q  <= '1;
      core_vld_q <= '0;
      core_idx_q <= '0;
    end else begin
      irq_q <= irq_in;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (trig_ok && trig_src == IDX_W'(s))
          pend_q[s] <= wr_data[FLAG_BIT];
        else if (irq_in[s] != irq_q[s])
          pend_q[s] <= irq_in[s];

        if (set_vec[s])      enab_q[s] <= 1'b1;
        else if (clr_vec[s]) enab_q[s] <= 1'b0;

        if (pinmap_wr && pin_ok && wr_index == IDX_W'(s)) begin
          pin_q[s]     <= wr_data[PIN_FIELD_W-1:0];
          pinflag_q[s] <= wr_data[FLAG_BIT];
        end

        if (coremap_wr && wr_index == IDX_W'(s)) begin
          if (low_bit == 32) begin
            core_vld_q[s] <= 1'b0;
          end else if (low_bit < NUM_CORES) begin
            core_vld_q[s] <= 1'b1;
            core_idx_q[s] <= CORE_W'(low_bit);
          end
        end
      end
    end
  end

  AST_SET_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((enab_q & $past(set_vec)) == $past(set_vec))); // R3
  AST_CLR_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((enab_q & $past(clr_vec)) == '0)); // R3
  AST_TRIG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> (pend_q[$past(trig_src)] == $past(wr_data[FLAG_BIT]))); // R7
  AST_PIN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pinmap_wr && !pin_ok) |=> $stable(pin_q)); // R5
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int NUM_OUT  = NUM_CORES * NUM_PINS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SRC-1:0]                  pend_q,
  input  logic [NUM_SRC-1:0]                  enab_q,
  input  logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] pin_q,
  input  logic [NUM_SRC-1:0]                  core_vld_q,
  input  logic [NUM_SRC-1:0][CORE_W-1:0]      core_idx_q,
  output logic [NUM_OUT-1:0]                  core_irq
);
  logic [NUM_SRC-1:0] live;
  assign live = pend_q & enab_q & core_vld_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      always_comb begin
        core_irq[c*NUM_PINS+p] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
          if (live[s] && core_idx_q[s] == CORE_W'(c) &&
              pin_q[s] == PIN_FIELD_W'(p))
            core_irq[c*NUM_PINS+p] = 1'b1;
        end
      end
    end
  end

  AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq != '0) |-> ((pend_q & enab_q) != '0)); // R4
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q == '0) |-> (core_irq == '0)); // R8
endmodule

// File: rtl/irq_regread.sv
module irq_regread
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 256,
  parameter int NUM_CORES = 4,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int WORDS    = (NUM_SRC + 31) / 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  region_e                             rd_region,
  input  logic [IDX_W-1:0]                    rd_index,
  input  logic [NUM_SRC-1:0]                  pend_q,
  input  logic [NUM_SRC-1:0]                  enab_q,
  input  logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] pin_q,
  input  logic [NUM_SRC-1:0]                  pinflag_q,
  input  logic [NUM_SRC-1:0]                  core_vld_q,
  input  logic [NUM_SRC-1:0][CORE_W-1:0]      core_idx_q,
  output logic                                rvalid,
  output logic [31:0]                         rdata
);
  logic [WORDS*32-1:0] pend_pad, enab_pad;
  logic [31:0]         rd_word;

  assign pend_pad = (WORDS*32)'(pend_q);
  assign enab_pad = (WORDS*32)'(enab_q);

  always_comb begin
    rd_word = '0;
    case (rd_region)
      RG_PEND, RG_ENAB: begin
        for (int w = 0; w < WORDS; w++) begin
          if (rd_index == IDX_W'(w))
            rd_word = (rd_region == RG_PEND) ? pend_pad[w*32 +: 32]
                                             : enab_pad[w*32 +: 32];
        end
      end
      RG_PINMAP, RG_COREMAP: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (rd_index == IDX_W'(s)) begin
            if (rd_region == RG_PINMAP)
              rd_word = {pinflag_q[s], {(31-PIN_FIELD_W){1'b0}}, pin_q[s]};
            else if (core_vld_q[s])
              rd_word = 32'(1) << core_idx_q[s];
          end
        end
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_word : '0;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R9
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid); // R9
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int ADDR_W   = 3 + IDX_W,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int NUM_OUT  = NUM_CORES * NUM_PINS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  output logic [NUM_OUT-1:0]   core_irq
);
  logic [NUM_SRC-1:0]                  pend_q, enab_q, pinflag_q, core_vld_q;
  logic [NUM_SRC-1:0][PIN_FIELD_W-1:0] pin_q;
  logic [NUM_SRC-1:0][CORE_W-1:0]      core_idx_q;
  region_e                             region;
  logic [IDX_W-1:0]                    index;

  assign region = region_e'(bus_addr[ADDR_W-1 -: 3]);
  assign index  = bus_addr[IDX_W-1:0];

  irq_src_bank #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .wr_en(bus_valid && bus_write), .wr_region(region), .wr_index(index),
    .wr_data(bus_wdata),
    .pend_q(pend_q), .enab_q(enab_q), .pin_q(pin_q), .pinflag_q(pinflag_q),
    .core_vld_q(core_vld_q), .core_idx_q(core_idx_q)
  );

  irq_fanout #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS)) u_fanout (
    .clk(clk), .rst_n(rst_n),
    .pend_q(pend_q), .enab_q(enab_q), .pin_q(pin_q),
    .core_vld_q(core_vld_q), .core_idx_q(core_idx_q), .core_irq(core_irq)
  );

  irq_regread #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES)) u_read (
    .clk(clk), .rst_n(rst_n),
    .rd_en(bus_valid && !bus_write), .rd_region(region), .rd_index(index),
    .pend_q(pend_q), .enab_q(enab_q), .pin_q(pin_q), .pinflag_q(pinflag_q),
    .core_vld_q(core_vld_q), .core_idx_q(core_idx_q),
    .rvalid(bus_rvalid), .rdata(bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (core_irq == '0 && !bus_rvalid)); // R1
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int NS = 16, NC = 3, NP = 4, NO = NC*NP, AW = 7;

  logic          clk = 0, rst_n = 0;
  logic [NS-1:0] irq_in = '0;
  logic          bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NO-1:0] core_irq;

  irq_router #(.NUM_SRC(NS), .NUM_CORES(NC), .NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .core_irq(core_irq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NS-1:0] m_pend = '0, m_en = '0, m_cv = '0;
  int m_pin[NS], m_core[NS];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] rg, int idx, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = {rg, 4'(idx)}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [2:0] rg, int idx, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = {rg, 4'(idx)};
    @(negedge clk);
    bus_valid = 0;
    if (bus_rvalid !== 1'b1) begin checks++; fails++; $display("FAIL R9 rvalid actual=0 expected=1"); end
    d = bus_rdata;
  endtask

  function automatic logic [NO-1:0] exp_out();
    logic [NO-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      if (m_pend[s] && m_en[s] && m_cv[s]) r[m_core[s]*NP + m_pin[s]] = 1'b1;
    return r;
  endfunction

  task automatic chk_out(string tag);
    check(tag, 32'(core_irq), 32'(exp_out()));
  endtask

  initial begin
    logic [31:0] d;
    for (int s = 0; s < NS; s++) begin m_pin[s] = 0; m_core[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", 32'(core_irq), 0);
    rd(3'd0, 0, d); check("R1 pending", d, 0);
    rd(3'd1, 0, d); check("R1 enable", d, 0);
    for (int s = 0; s < NS; s++) begin
      rd(3'd5, s, d); check("R1 pinmap", d, 32'h8000_0000);
      rd(3'd6, s, d); check("R1 coremap", d, 0);
    end
    // R4 exhaustive sweep of source/core/pin
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        for (int p = 0; p < NP; p++) begin
          wr(3'd5, s, 32'(p)); m_pin[s] = p;
          wr(3'd6, s, 32'(1) << c); m_cv[s] = 1; m_core[s] = c;
          wr(3'd2, 0, 32'(1) << s); m_en[s] = 1;
          chk_out("R4 enabled not pending");
          wr(3'd4, 0, 32'h8000_0000 | 32'(s)); m_pend[s] = 1;
          chk_out("R4 routed");
          check("R4 onehot", 32'(core_irq), 32'(1) << (c*NP+p));
          wr(3'd4, 0, 32'(s)); m_pend[s] = 0;
          chk_out("R7 trigger clear");
          wr(3'd3, 0, 32'(1) << s); m_en[s] = 0;
        end
    // R4 OR of two sources on one pair
    wr(3'd5, 2, 32'd2); m_pin[2] = 2; wr(3'd6, 2, 32'b10); m_core[2] = 1;
    wr(3'd5, 9, 32'd2); m_pin[9] = 2; wr(3'd6, 9, 32'b10); m_core[9] = 1;
    wr(3'd2, 0, 32'h0204); m_en[2] = 1; m_en[9] = 1;
    wr(3'd4, 0, 32'h8000_0002); m_pend[2] = 1;
    wr(3'd4, 0, 32'h8000_0009); m_pend[9] = 1;
    chk_out("R4 OR both");
    wr(3'd4, 0, 32'h0000_0002); m_pend[2] = 0;
    chk_out("R4 OR one left");
    check("R4 OR bit", 32'(core_irq[1*NP+2]), 1);
    // R2 packed reads
    wr(3'd2, 0, 32'h0000_A5C3); m_en = m_en | 16'hA5C3;
    rd(3'd1, 0, d); check("R2 enable word", d, 32'(m_en));
    rd(3'd0, 0, d); check("R2 pending word", d, 32'(m_pend));
    rd(3'd1, 1, d); check("R9 enable word past count", d, 0);
    wr(3'd2, 1, 32'hFFFF_FFFF);
    rd(3'd1, 0, d); check("R9 write past count", d, 32'(m_en));
    // R3 zero bits keep state, ones clear
    wr(3'd3, 0, 32'h0000_0001); m_en[0] = 0;
    rd(3'd1, 0, d); check("R3 clear one bit", d, 32'(m_en));
    chk_out("R3 outputs");
    // R5 out-of-range pin ignored
    wr(3'd5, 5, 32'h0000_0003); m_pin[5] = 3;
    wr(3'd5, 5, 32'h8000_0004);
    rd(3'd5, 5, d); check("R5 pin rejected", d, 32'h0000_0003);
    wr(3'd5, 5, 32'h8000_0001); m_pin[5] = 1;
    rd(3'd5, 5, d); check("R5 pin flag", d, 32'h8000_0001);
    // R6 core map encode, reject, unmap
    wr(3'd6, 7, 32'b0110); m_cv[7] = 1; m_core[7] = 1;
    rd(3'd6, 7, d); check("R6 lowest bit", d, 32'b0010);
    wr(3'd6, 7, 32'b1000);
    rd(3'd6, 7, d); check("R6 reject core", d, 32'b0010);
    wr(3'd2, 0, 32'h80); m_en[7] = 1;
    wr(3'd4, 0, 32'h8000_0007); m_pend[7] = 1;
    chk_out("R6 mapped active");
    wr(3'd6, 7, 32'h0); m_cv[7] = 0;
    rd(3'd6, 7, d); check("R6 unmapped read", d, 0);
    chk_out("R6 unmapped silent");
    // R7 out-of-range trigger ignored
    rd(3'd0, 0, d);
    wr(3'd4, 0, 32'h8000_0010);
    rd(3'd0, 0, d); check("R7 trigger past count", d, 32'(m_pend));
    // R8 level input while disabled
    wr(3'd3, 0, 32'h0000_FFFF); m_en = '0;
    wr(3'd6, 12, 32'b100); m_cv[12] = 1; m_core[12] = 2;
    wr(3'd5, 12, 32'd3); m_pin[12] = 3;
    @(negedge clk); irq_in[12] = 1; m_pend[12] = 1;
    @(negedge clk);
    check("R8 disabled silent", 32'(core_irq), 0);
    rd(3'd0, 0, d); check("R8 pending follows", d, 32'(m_pend));
    wr(3'd2, 0, 32'h1000); m_en[12] = 1;
    chk_out("R8 enable passes");
    @(negedge clk); irq_in[12] = 0; m_pend[12] = 0;
    @(negedge clk);
    chk_out("R8 level drop");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule